// File: doc/BRIEF.md
# Peak-and-Hold PWM Load Switch Controller

This block controls the gate of a low-side switch that drives a solenoid, valve, relay or heater. When the enable input rises, the gate is held fully on for a programmable number of clock cycles. This pull-in phase gives the load a strong initial closure. After it, the gate switches to a fixed-frequency PWM hold with a programmable duty value, which saves power while the load is held.

The PWM carrier is a free-running counter that is never realigned to the enable edge. The first PWM pulse after the pull-in phase can therefore run on into part of the programmed on-time.

Status inputs come from external comparators and are already synchronous to the clock:
- Over-current and under-current pull the active-low fault flag down only while the gate is conducting. The flag is not latched, so during the hold phase it pulses in step with the PWM waveform.
- An over-temperature trip acts like dropping enable. It forces the gate off, cancels the pull-in count and holds the flag low until a separate cool-release input is seen. If enable is still high at that point, the sequence starts again with a full pull-in phase.

With the default parameters and a 24.576 MHz clock, the carrier period is 1024 clocks, which gives 24 kHz.

Top module: `pkhold_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, the gate output is 0 and the fault flag is 1.
- R2: With a nonzero pull-in count D, the gate is 1 in each of the D cycles that follow the clock edge that first samples enable high. A cycle here is one clock period, seen at the outputs after that edge.
- R3: A pull-in count of 0 skips the full-on phase. PWM hold begins at the first edge that samples enable high, so the first 1024 cycles show exactly the programmed on-count.
- R4: In the hold phase, the carrier period is 2^PERIOD_W clocks (1024 by default). Over any run of that many consecutive cycles, the gate is high for exactly as many cycles as the duty value, taken as an unsigned number.
- R5: A duty value below 103 (the smallest count that is at least 10% of 1024) acts as 103. Values from 103 to 1022 are used as given, so a higher value never gives fewer on-cycles.
- R6: A duty value of all ones (1023) holds the gate continuously high throughout the hold phase, with no off cycle at the period wrap.
- R7: An edge that samples enable low turns the gate off in the following cycle. The next enable high starts a full pull-in phase again.
- R8: Over-current or under-current drives the flag to 0 only in cycles where the gate is 1. With the gate at 0, these inputs leave the flag at 1, and the flag is not latched.
- R9: An edge that samples the hot-trip input turns the gate off and the flag to 0. Both stay that way, whatever the trip input does, until an edge samples cool-release with hot-trip low.
- R10: If enable is high at the edge that accepts cool-release, the gate is 1 for the next D cycles, which is a new pull-in phase, and the flag returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request; high turns the load on |
| pullin_cnt_i | input | 24 | Length of the full-on phase, in clocks |
| duty_i | input | 10 | Hold-phase on-count per carrier period |
| over_cur_i | input | 1 | Over-current comparator output |
| under_cur_i | input | 1 | Under-current comparator output |
| hot_trip_i | input | 1 | Over-temperature trip comparator |
| cool_rel_i | input | 1 | Temperature release comparator |
| gate_o | output | 1 | Switch gate drive, high = conducting |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The hardest situation to reach from the ports is a thermal release while enable stays high. The bench first lets the controller settle into PWM hold, then pulses the hot-trip input and holds it low for several cycles with cool-release still low, and checks that the latch holds the gate off. It then raises cool-release and counts the cycles of the new pull-in phase. The carrier phase is not visible at the ports, so duty is measured as an on-count over a whole period window, which does not depend on where the carrier happens to be. Current-fault gating is checked cycle by cycle against the gate, so the flag must pulse with the PWM waveform.

// File: rtl/pkh_pkg.sv
package pkh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEAK = 2'd1,
    ST_HOLD = 2'd2
  } pkh_state_e;

  // smallest on-count that is at least pct percent of 2**w
  function automatic int unsigned floor_count(int unsigned w, int unsigned pct);
    return (((1 << w) * pct) + 99) / 100;
  endfunction
endpackage

// File: rtl/pkh_carrier.sv
module pkh_carrier #(
  parameter int unsigned PERIOD_W = 10,
  parameter int unsigned MIN_PCT  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] duty_i,
  output logic                pwm_on_o
);
  localparam int unsigned MIN_CNT = pkh_pkg::floor_count(PERIOD_W, MIN_PCT);
  localparam logic [PERIOD_W-1:0] MIN_VAL = PERIOD_W'(MIN_CNT);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [PERIOD_W-1:0] duty_eff;
  logic                full_on;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    full_on  = &duty_i;
    duty_eff = (duty_i < MIN_VAL) ? MIN_VAL : duty_i;
    pwm_on_o = full_on | (cnt_q < duty_eff);
  end
endmodule

// File: rtl/pkh_thermal.sv
module pkh_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic cool_i,
  output logic latch_d_o,
  output logic latch_q_o
);
  logic lat_q, lat_d;

  always_comb begin
    if (hot_i)       lat_d = 1'b1;
    else if (cool_i) lat_d = 1'b0;
    else             lat_d = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign latch_d_o = lat_d;
  assign latch_q_o = lat_q;
endmodule

// File: rtl/pkh_seq.sv
module pkh_seq #(
  parameter int unsigned DELAY_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic [DELAY_W-1:0] pullin_i,
  input  logic               therm_i,
  input  logic               pwm_on_i,
  output logic               gate_d_o
);
  import pkh_pkg::*;

  pkh_state_e         st_q, st_d;
  logic [DELAY_W-1:0] dcnt_q, dcnt_d;
  logic               dcnt_en;

  always_comb begin
    st_d    = st_q;
    dcnt_d  = dcnt_q;
    dcnt_en = 1'b0;
    if (!enable_i || therm_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          dcnt_en = 1'b1;
          dcnt_d  = pullin_i;
          st_d    = (pullin_i == '0) ? ST_HOLD : ST_PEAK;
        end
        ST_PEAK: begin
          if (dcnt_q <= DELAY_W'(1)) begin
            st_d = ST_HOLD;
          end else begin
            dcnt_en = 1'b1;
            dcnt_d  = dcnt_q - 1'b1;
          end
        end
        ST_HOLD: st_d = ST_HOLD;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt_q <= '0;
    else if (dcnt_en) dcnt_q <= dcnt_d;
  end

  always_comb begin
    gate_d_o = (st_d == ST_PEAK) | ((st_d == ST_HOLD) & pwm_on_i);
  end
endmodule

// File: rtl/pkhold_ctrl.sv
module pkhold_ctrl #(
  parameter int unsigned PERIOD_W = 10,
  parameter int unsigned DELAY_W  = 24,
  parameter int unsigned MIN_PCT  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable_i,
  input  logic [DELAY_W-1:0]  pullin_cnt_i,
  input  logic [PERIOD_W-1:0] duty_i,
  input  logic                over_cur_i,
  input  logic                under_cur_i,
  input  logic                hot_trip_i,
  input  logic                cool_rel_i,
  output logic                gate_o,
  output logic                fault_n_o
);
  logic pwm_on, therm_d, therm_q, gate_d, flag_n_d;
  logic gate_q, flag_n_q;

  pkh_carrier #(.PERIOD_W(PERIOD_W), .MIN_PCT(MIN_PCT)) u_carrier (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .pwm_on_o(pwm_on)
  );

  pkh_thermal u_thermal (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_trip_i), .cool_i(cool_rel_i),
    .latch_d_o(therm_d), .latch_q_o(therm_q)
  );

  pkh_seq #(.DELAY_W(DELAY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .pullin_i(pullin_cnt_i),
    .therm_i(therm_d), .pwm_on_i(pwm_on), .gate_d_o(gate_d)
  );

  always_comb begin
    flag_n_d = ~(therm_d | ((over_cur_i | under_cur_i) & gate_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      flag_n_q <= 1'b1;
    end else begin
      gate_q   <= gate_d;
      flag_n_q <= flag_n_d;
    end
  end

  assign gate_o    = gate_q;
  assign fault_n_o = flag_n_q;
endmodule

// File: rtl/pkhold_ctrl_chk.sv
module pkhold_ctrl_chk #(
  parameter int unsigned DELAY_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable_i,
  input logic [DELAY_W-1:0] pullin_cnt_i,
  input logic               over_cur_i,
  input logic               under_cur_i,
  input logic               hot_trip_i,
  input logic               gate_o,
  input logic               fault_n_o,
  input logic               therm_q
);
  assert_en_low_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !gate_o);

  assert_trip_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hot_trip_i |=> (!gate_o && !fault_n_o));

  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    therm_q |-> (!gate_o && !fault_n_o));

  assert_cur_flag_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !fault_n_o) |-> $past(over_cur_i || under_cur_i));

  assert_pullin_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !$past(enable_i) && !hot_trip_i && !therm_q && pullin_cnt_i != '0)
      |=> gate_o);

  assert_release_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(therm_q) && $past(enable_i) && pullin_cnt_i != '0) |-> gate_o);
endmodule

bind pkhold_ctrl pkhold_ctrl_chk #(.DELAY_W(DELAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .pullin_cnt_i(pullin_cnt_i),
  .over_cur_i(over_cur_i), .under_cur_i(under_cur_i), .hot_trip_i(hot_trip_i),
  .gate_o(gate_o), .fault_n_o(fault_n_o), .therm_q(therm_q)
);

// File: tb/sim_pkhold_ctrl.sv
`timescale 1ns/100ps
module sim_pkhold_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic enable_i, over_cur_i, under_cur_i, hot_trip_i, cool_rel_i;
  logic [23:0] pullin_cnt_i;
  logic [9:0]  duty_i;
  logic gate_o, fault_n_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pkhold_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .pullin_cnt_i(pullin_cnt_i),
    .duty_i(duty_i), .over_cur_i(over_cur_i), .under_cur_i(under_cur_i),
    .hot_trip_i(hot_trip_i), .cool_rel_i(cool_rel_i),
    .gate_o(gate_o), .fault_n_o(fault_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_on(output int n);
    n = 0;
    repeat (1024) begin
      @(negedge clk);
      n += int'(gate_o);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; enable_i = 0; over_cur_i = 0; under_cur_i = 0;
    hot_trip_i = 0; cool_rel_i = 0; pullin_cnt_i = 24'd40; duty_i = 10'd512;
    repeat (3) @(negedge clk);
    chk(gate_o == 1'b0 && fault_n_o == 1'b1, "R1 in reset", {gate_o, fault_n_o}, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(gate_o == 1'b0 && fault_n_o == 1'b1, "R1 after reset", {gate_o, fault_n_o}, 1);
  endtask

  task automatic t_pullin(input int d);
    int hi = 0;
    enable_i = 0; pullin_cnt_i = 24'(d); duty_i = 10'd103;
    @(negedge clk); enable_i = 1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      hi += int'(gate_o);
    end
    chk(hi == d, "R2 pull-in all on", hi, d);
    // the run must end within one carrier period after pull-in
    hi = 0;
    repeat (1100) begin
      @(negedge clk);
      if (!gate_o) hi = 1;
    end
    chk(hi == 1, "R2 pwm follows pull-in", hi, 1);
    enable_i = 0; @(negedge clk);
  endtask

  task automatic t_duty(input int d, input int exp, input string req);
    int n;
    enable_i = 0; pullin_cnt_i = 24'd4; duty_i = 10'(d);
    @(negedge clk); enable_i = 1;
    repeat (10) @(negedge clk);
    count_on(n);
    chk(n == exp, req, n, exp);
    enable_i = 0; @(negedge clk);
  endtask

  task automatic t_zero;
    int n;
    enable_i = 0; pullin_cnt_i = 24'd0; duty_i = 10'd200;
    @(negedge clk); enable_i = 1;
    count_on(n);
    chk(n == 200, "R3 zero pull-in straight to pwm", n, 200);
    enable_i = 0; @(negedge clk);
  endtask

  task automatic t_enable_low;
    int hi = 0;
    enable_i = 0; pullin_cnt_i = 24'd50; duty_i = 10'd103;
    @(negedge clk); enable_i = 1;
    repeat (20) @(negedge clk);
    enable_i = 0;
    @(negedge clk);
    chk(gate_o == 1'b0, "R7 gate off after enable low", gate_o, 0);
    repeat (3) @(negedge clk);
    enable_i = 1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      hi += int'(gate_o);
    end
    chk(hi == 50, "R7 pull-in restarts in full", hi, 50);
    enable_i = 0; @(negedge clk);
  endtask

  task automatic t_cur_fault;
    int lows = 0, bad = 0;
    enable_i = 0; pullin_cnt_i = 24'd20; duty_i = 10'd512;
    @(negedge clk); enable_i = 1; under_cur_i = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (fault_n_o) bad++;
    end
    chk(bad == 0, "R8 flag low during pull-in", bad, 0);
    bad = 0;
    repeat (1024) begin
      @(negedge clk);
      if (fault_n_o != !gate_o) bad++;
      if (!fault_n_o) lows++;
    end
    chk(bad == 0, "R8 flag tracks gate", bad, 0);
    chk(lows == 512, "R8 flag pulses with pwm", lows, 512);
    under_cur_i = 0; over_cur_i = 1;
    enable_i = 0;
    repeat (2) @(negedge clk);
    chk(fault_n_o == 1'b1 && gate_o == 1'b0, "R8 no flag when off", fault_n_o, 1);
    over_cur_i = 0; @(negedge clk);
  endtask

  task automatic t_thermal;
    int bad = 0, hi = 0;
    enable_i = 0; pullin_cnt_i = 24'd30; duty_i = 10'd700;
    @(negedge clk); enable_i = 1;
    repeat (40) @(negedge clk);
    hot_trip_i = 1;
    @(negedge clk);
    chk(gate_o == 1'b0 && fault_n_o == 1'b0, "R9 trip forces off", {gate_o, fault_n_o}, 0);
    hot_trip_i = 0;
    repeat (12) begin
      @(negedge clk);
      if (gate_o || fault_n_o) bad++;
    end
    chk(bad == 0, "R9 latch holds until release", bad, 0);
    cool_rel_i = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      hi += int'(gate_o & fault_n_o);
    end
    chk(hi == 30, "R10 recovery restarts pull-in", hi, 30);
    cool_rel_i = 0; enable_i = 0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_pullin(40);
    t_pullin(1);
    t_zero();
    t_duty(512, 512, "R4 half duty on-count");
    t_duty(300, 300, "R4 arbitrary duty on-count");
    t_duty(5, 103, "R5 low clamp");
    t_duty(0, 103, "R5 zero clamps");
    t_duty(103, 103, "R5 floor value kept");
    t_duty(1022, 1022, "R5 near top kept");
    t_duty(1023, 1024, "R6 all ones continuous");
    t_enable_low();
    t_cur_fault();
    t_thermal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule